// File: doc/BRIEF.md
# Dynamic phase-averaging loop controller

This block steers the digital control word of an oscillator so that the oscillator runs at an integer multiple of a reference clock. It runs on a system clock. Each reference edge reaches it as a one-cycle `ref_tick` pulse. With each tick it also receives `cnt_snap`, the number of oscillator cycles counted since the counter was last cleared. It drives `cnt_clr` to clear that counter. There is no phase detector, divider or loop filter. The controller lets the oscillator count run for a power-of-two number of reference cycles, then compares the count with the multiplication word scaled by that power of two.

The controller has numbered states. State 0 lasts one clock, holds the counter in clear and restarts the reference count. In state i (1 to `TOP_STATE`) the comparison is made on the tick that brings the reference count to 2^i. Below that, the low i bits of the snapshot act as a tolerance band. A match keeps the control word and moves to state i+1, which doubles the averaging window. A mismatch moves the control word one step toward the target and returns to state 0. The step starts at a quarter of full scale and halves after every correction, down to a floor of 1. Acquisition is therefore a binary search that ends in unit steps. A match in the top state raises the lock flag and starts a new round from state 0.

Top module: `dpa_loop_ctrl`

## Requirements
- R1: While `rst_n` is low and straight after it is released, `dcw` is 0x8000, `locked` is 0 and the correction step is 0x4000.
- R2: State 0, entered at reset and after every correction or top-state match, lasts exactly one clock and holds `cnt_clr` high there. A `ref_tick` in that clock is not counted. In every other state `cnt_clr` is low.
- R3: In state i (i from 1 to `TOP_STATE`, default 6), counting ticks from the end of state 0, a comparison is made only on tick number 2^i. `cnt_snap` has no effect on any other tick.
- R4: At a comparison, the quotient Q = `cnt_snap` >> i is compared with the effective multiplication word N. When Q equals N (the low i bits being the tolerance band), `dcw` is kept and the controller moves to state i+1 with `cnt_clr` still low.
- R5: When Q < N, `dcw` rises by the current step. When Q > N, `dcw` falls by the step. Either way the controller returns to state 0, so `cnt_clr` is high in the clock after the comparison. A higher `dcw` means a faster oscillator.
- R6: After every correction the step halves, with a floor of 1. From reset the steps are 0x4000, 0x2000, …, 1, 1, ….
- R7: `dcw` saturates at 0xFFFF going up and at 0x0000 going down, and never wraps.
- R8: A `mult_word` of 0 or 1 acts as 2.
- R9: `locked` rises after a match in state `TOP_STATE`, which also returns the controller to state 0. It falls with the next correction and keeps its value at every other match.
- R10: `dcw` changes only in the clock after a comparison tick that ended in a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| ref_tick | input | 1 | One-cycle pulse for each reference clock edge |
| cnt_snap | input | CNT_W (14) | Oscillator cycles counted since the last clear, valid together with `ref_tick` |
| mult_word | input | MULT_W (8) | Target multiplication factor |
| dcw | output | DCW_W (16) | Oscillator control word |
| cnt_clr | output | 1 | Clears the external oscillator cycle counter (high in state 0) |
| locked | output | 1 | Frequency held within the band over the longest window |

## Verification
The assertions take `ref_tick` to be a single-cycle pulse. They also take `cnt_snap` to be meaningful only when the tick is high, and `rst_n` to change away from the active clock edge. Given these, they check that every control-word change follows a tick, comes together with a return to state 0 and a cleared lock, and never wraps around either end of the range. The stimulus drives every tick as a pulse exactly one clock wide, changes inputs on the falling edge, and holds `cnt_snap` at a deliberately wrong value on the ticks that do not end a window. A snapshot that leaked into a comparison early would therefore show up at the ports.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  // Result of one window comparison.
  typedef enum logic [1:0] {
    CMP_MATCH = 2'd0,
    CMP_SLOW  = 2'd1,
    CMP_FAST  = 2'd2
  } cmp_e;

endpackage

// File: rtl/dpa_window.sv
// Window sequencer: state index, reference-tick count, end-of-window strobe.
module dpa_window #(
  parameter int TOP_STATE = 6,
  parameter int ST_W      = 3,
  parameter int RC_W      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic            hit,
  output logic [ST_W-1:0] st,
  output logic            win_end,
  output logic            at_top,
  output logic            clr
);

  localparam logic [ST_W-1:0] ST_TOP = ST_W'(TOP_STATE);

  logic [ST_W-1:0] st_q, st_d;
  logic [RC_W-1:0] rc_q, rc_d, rc_inc, target;

  assign rc_inc  = rc_q + RC_W'(1);
  assign target  = RC_W'(1) << st_q;
  assign win_end = (st_q != '0) && ref_tick && (rc_inc == target);
  assign at_top  = (st_q == ST_TOP);
  assign clr     = (st_q == '0);
  assign st      = st_q;

  always_comb begin
    st_d = st_q;
    rc_d = rc_q;
    if (st_q == '0) begin
      st_d = ST_W'(1);
      rc_d = '0;
    end else if (win_end) begin
      if (hit && !at_top) begin
        st_d = st_q + ST_W'(1);
        rc_d = rc_inc;
      end else begin
        st_d = '0;
        rc_d = '0;
      end
    end else if (ref_tick) begin
      rc_d = rc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      rc_q <= '0;
    end else begin
      st_q <= st_d;
      rc_q <= rc_d;
    end
  end

endmodule

// File: rtl/dpa_decide.sv
// Magnitude comparison of the sliced oscillator count against the target.
module dpa_decide #(
  parameter int CNT_W  = 14,
  parameter int MULT_W = 8,
  parameter int ST_W   = 3
) (
  input  logic [CNT_W-1:0]  cnt_snap,
  input  logic [MULT_W-1:0] mult_word,
  input  logic [ST_W-1:0]   st,
  output dpa_pkg::cmp_e     verdict
);

  logic [MULT_W-1:0] n_eff;
  logic [CNT_W-1:0]  quot;
  logic [CNT_W-1:0]  n_wide;

  assign n_eff  = (mult_word < MULT_W'(2)) ? MULT_W'(2) : mult_word;
  assign n_wide = CNT_W'(n_eff);
  assign quot   = cnt_snap >> st;

  always_comb begin
    if (quot == n_wide)     verdict = dpa_pkg::CMP_MATCH;
    else if (quot < n_wide) verdict = dpa_pkg::CMP_SLOW;
    else                    verdict = dpa_pkg::CMP_FAST;
  end

endmodule

// File: rtl/dpa_dcw.sv
// Control word and step register with saturation, plus the lock flag.
module dpa_dcw #(
  parameter int DCW_W    = 16,
  parameter int STEP_MIN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic             at_top,
  input  dpa_pkg::cmp_e    verdict,
  output logic [DCW_W-1:0] dcw,
  output logic             locked
);

  localparam logic [DCW_W-1:0] MID   = {1'b1, {(DCW_W-1){1'b0}}};
  localparam logic [DCW_W-1:0] STEP0 = {2'b01, {(DCW_W-2){1'b0}}};
  localparam logic [DCW_W-1:0] FULL  = {DCW_W{1'b1}};
  localparam logic [DCW_W-1:0] FLOOR = DCW_W'(STEP_MIN);

  logic [DCW_W-1:0] dcw_q, dcw_d, step_q, step_d, step_half;
  logic [DCW_W:0]   sum;
  logic             lock_q, lock_d, upd;

  assign sum       = {1'b0, dcw_q} + {1'b0, step_q};
  assign step_half = step_q >> 1;
  assign upd       = win_end;

  always_comb begin
    dcw_d  = dcw_q;
    step_d = step_q;
    lock_d = lock_q;
    if (upd) begin
      unique case (verdict)
        dpa_pkg::CMP_SLOW: begin
          dcw_d  = sum[DCW_W] ? FULL : sum[DCW_W-1:0];
          step_d = (step_half < FLOOR) ? FLOOR : step_half;
          lock_d = 1'b0;
        end
        dpa_pkg::CMP_FAST: begin
          dcw_d  = (dcw_q < step_q) ? '0 : dcw_q - step_q;
          step_d = (step_half < FLOOR) ? FLOOR : step_half;
          lock_d = 1'b0;
        end
        default: begin
          if (at_top) lock_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcw_q  <= MID;
      step_q <= STEP0;
      lock_q <= 1'b0;
    end else if (upd) begin
      dcw_q  <= dcw_d;
      step_q <= step_d;
      lock_q <= lock_d;
    end
  end

  assign dcw    = dcw_q;
  assign locked = lock_q;

endmodule

// File: rtl/dpa_loop_ctrl.sv
// Top: dynamic phase-averaging loop controller.
module dpa_loop_ctrl #(
  parameter int DCW_W     = 16,
  parameter int MULT_W    = 8,
  parameter int TOP_STATE = 6,
  parameter int STEP_MIN  = 1,
  parameter int CNT_W     = MULT_W + TOP_STATE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [CNT_W-1:0]  cnt_snap,
  input  logic [MULT_W-1:0] mult_word,
  output logic [DCW_W-1:0]  dcw,
  output logic              cnt_clr,
  output logic              locked
);

  localparam int ST_W = $clog2(TOP_STATE + 1);
  localparam int RC_W = TOP_STATE + 1;

  logic [ST_W-1:0] st;
  logic            win_end, at_top, hit;
  dpa_pkg::cmp_e   verdict;

  assign hit = (verdict == dpa_pkg::CMP_MATCH);

  dpa_window #(.TOP_STATE(TOP_STATE), .ST_W(ST_W), .RC_W(RC_W)) u_window (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .hit(hit),
    .st(st), .win_end(win_end), .at_top(at_top), .clr(cnt_clr)
  );

  dpa_decide #(.CNT_W(CNT_W), .MULT_W(MULT_W), .ST_W(ST_W)) u_decide (
    .cnt_snap(cnt_snap), .mult_word(mult_word), .st(st), .verdict(verdict)
  );

  dpa_dcw #(.DCW_W(DCW_W), .STEP_MIN(STEP_MIN)) u_dcw (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .at_top(at_top),
    .verdict(verdict), .dcw(dcw), .locked(locked)
  );

endmodule

// File: rtl/dpa_loop_ctrl_chk.sv
// Property checker bound to the controller.
module dpa_loop_ctrl_chk #(
  parameter int DCW_W     = 16,
  parameter int TOP_STATE = 6,
  parameter int ST_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic [DCW_W-1:0] dcw,
  input logic             cnt_clr,
  input logic             locked,
  input logic [ST_W-1:0]  st
);

  // R2
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !cnt_clr);

  // R3
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st <= ST_W'(TOP_STATE));

  // R10
  dcw_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dcw) |-> $past(ref_tick));

  // R5
  dcw_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dcw) |-> cnt_clr);

  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dcw) |-> !locked);

  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> cnt_clr);

  // R7
  no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dcw[DCW_W-1:DCW_W-2]) == 2'b11) |-> dcw[DCW_W-1]);

  // R7
  no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dcw[DCW_W-1:DCW_W-2]) == 2'b00) |-> !dcw[DCW_W-1]);

endmodule

bind dpa_loop_ctrl dpa_loop_ctrl_chk #(
  .DCW_W(DCW_W), .TOP_STATE(TOP_STATE), .ST_W(ST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dcw(dcw),
  .cnt_clr(cnt_clr), .locked(locked), .st(st)
);

// File: tb/tb_dpa_loop_ctrl.sv
module tb_dpa_loop_ctrl;

  logic        clk;
  logic        rst_n;
  logic        ref_tick;
  logic [13:0] cnt_snap;
  logic [7:0]  mult_word;
  logic [15:0] dcw;
  logic        cnt_clr;
  logic        locked;

  int nchk;
  int nerr;
  int exp_dcw;
  int exp_step;
  bit done;

  dpa_loop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cnt_snap(cnt_snap),
    .mult_word(mult_word), .dcw(dcw), .cnt_clr(cnt_clr), .locked(locked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected correction, from R5, R6 and R7.
  task automatic corr(input bit up);
    if (up) exp_dcw = (exp_dcw + exp_step > 65535) ? 65535 : exp_dcw + exp_step;
    else    exp_dcw = (exp_dcw < exp_step) ? 0 : exp_dcw - exp_step;
    exp_step = (exp_step > 1) ? exp_step / 2 : 1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_tick = 1'b0; cnt_snap = '0; mult_word = 8'd10;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    exp_dcw = 32768; exp_step = 16384;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int s);
    ref_tick = 1'b1; cnt_snap = 14'(s);
    @(negedge clk);
    ref_tick = 1'b0; cnt_snap = '0;
  endtask

  // Ticks of state i; only the last carries the real snapshot (R3).
  task automatic window(input int i, input int s);
    int n;
    n = (i == 1) ? 2 : (1 << (i - 1));
    for (int k = 0; k < n; k++) pulse((k == n - 1) ? s : 14'h3FFF);
  endtask

  task automatic miss1(input bit up);
    idle(1);
    window(1, up ? 0 : 14'h3FFF);
    corr(up);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_tick = 1'b0; cnt_snap = '0; mult_word = 8'd10;
    idle(1);
    check("R1 dcw in reset", int'(dcw), 32'h8000);
    check("R1 locked in reset", int'(locked), 0);
    do_reset();
    check("R1 dcw after reset", int'(dcw), 32'h8000);
    check("R2 clr in state 0", int'(cnt_clr), 1);
  endtask

  task automatic t_first_corrections();
    idle(1);
    check("R2 clr low after one clock", int'(cnt_clr), 0);
    pulse(0);
    check("R3 no compare on first tick", int'(dcw), 32'h8000);
    pulse(0);
    corr(1'b1);
    check("R5 slow raises dcw", int'(dcw), exp_dcw);
    check("R5 return to state 0", int'(cnt_clr), 1);
    miss1(1'b0);
    check("R6 halved step down", int'(dcw), exp_dcw);
    miss1(1'b1);
    check("R6 halved step up", int'(dcw), exp_dcw);
  endtask

  task automatic t_state0_ignore();
    pulse(0);
    pulse(0);
    check("R2 tick in state 0 not counted", int'(dcw), exp_dcw);
    check("R10 dcw held mid-window", int'(cnt_clr), 0);
    pulse(0);
    corr(1'b1);
    check("R2 window ends one tick later", int'(dcw), exp_dcw);
  endtask

  task automatic t_hit_lock();
    do_reset();
    mult_word = 8'd10;
    idle(1);
    for (int i = 1; i <= 6; i++) begin
      window(i, 10 << i);
      check("R4 match keeps dcw", int'(dcw), 32'h8000);
      if (i < 6) begin
        check("R4 match keeps counting", int'(cnt_clr), 0);
        check("R9 no lock before top", int'(locked), 0);
      end
    end
    check("R9 lock after top match", int'(locked), 1);
    check("R9 restart after top match", int'(cnt_clr), 1);
    miss1(1'b1);
    check("R9 lock drops on correction", int'(locked), 0);
    check("R5 dcw after lock loss", int'(dcw), exp_dcw);
  endtask

  task automatic t_threshold();
    do_reset();
    mult_word = 8'd10;
    idle(1);
    window(1, 21);
    check("R4 band top edge state 1", int'(dcw), 32'h8000);
    window(2, 43);
    check("R4 band top edge state 2", int'(dcw), 32'h8000);
    check("R4 still counting", int'(cnt_clr), 0);
    window(3, 88);
    corr(1'b0);
    check("R5 just above band lowers dcw", int'(dcw), exp_dcw);
    check("R5 restart after miss", int'(cnt_clr), 1);
  endtask

  task automatic t_small_mult();
    do_reset();
    mult_word = 8'd1;
    idle(1);
    window(1, 4);
    check("R8 word 1 acts as 2 (match)", int'(dcw), 32'h8000);
    window(2, 4);
    corr(1'b1);
    check("R8 word 1 acts as 2 (slow)", int'(dcw), exp_dcw);
    mult_word = 8'd0;
    idle(1);
    window(1, 3);
    corr(1'b1);
    check("R8 word 0 acts as 2", int'(dcw), exp_dcw);
  endtask

  task automatic t_clamp_hi();
    do_reset();
    mult_word = 8'd10;
    repeat (15) miss1(1'b1);
    check("R7 reaches full scale", int'(dcw), 32'hFFFF);
    miss1(1'b1);
    check("R7 saturates high", int'(dcw), 32'hFFFF);
    check("R6 step floor applied", exp_dcw, 32'hFFFF);
  endtask

  task automatic t_clamp_lo();
    do_reset();
    mult_word = 8'd10;
    repeat (16) miss1(1'b0);
    check("R7 reaches zero", int'(dcw), 0);
    miss1(1'b0);
    check("R7 saturates low", int'(dcw), 0);
  endtask

  initial begin
    nchk = 0; nerr = 0; done = 1'b0;
    t_reset();
    t_first_corrections();
    t_state0_ignore();
    t_hit_lock();
    t_threshold();
    t_small_mult();
    t_clamp_hi();
    t_clamp_lo();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule